// File: doc/BRIEF.md
# UART interrupt identification controller

This block merges the four interrupt causes of a buffered UART into one interrupt line and an 8-bit identification value that the CPU reads to learn which cause to service first. The causes are a receiver line condition (error or break), received data ready, an empty transmit holding register, and a change on the modem status lines. Each cause is gated by its own bit of a 4-bit enable value. Only the most urgent cause that is pending and enabled is encoded into the identification value.

The received-data cause depends on the FIFO mode. With the FIFOs off, it is pending whenever the receive buffer holds a character. With the FIFOs on, it is pending when the fill count reaches a selectable trigger level. It is also pending when characters have sat unread in the FIFO for four character times; this case is a time-out and is flagged by its own bit. The transmit-empty cause is an event: it is armed when the holding register becomes empty. It is cleared by a write to that register, or by a read of the identification value while it is the cause being reported.

The surrounding UART supplies the status levels, the pulses and the FIFO fill count. It also supplies a pulse once per character time. The FIFOs, the shifters and the register decoding sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 gates received data, bit 1 gates transmit-empty, bit 2 gates line status and bit 3 gates modem status. A source whose enable bit is 0 is never reported and never raises `irq`.
- R2: `ident[0]` is 0 while at least one enabled source is pending and 1 otherwise. `irq` is high exactly when `ident[0]` is 0.
- R3: `ident[2:1]` encodes the reported source: 2'b11 line status, 2'b10 received data, 2'b01 transmit-empty, 2'b00 modem status. It is 2'b00 when nothing is pending.
- R4: The priority order, from highest to lowest, is line status, received data, transmit-empty, modem status. Only the highest pending enabled source is reported.
- R5: With the FIFOs enabled, `trig_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 select trigger levels of 1, 4, 8 and 14 characters. Received data is pending when `rx_count` is at least the selected level.
- R6: With the FIFOs disabled, received data is pending exactly when `rx_count` is non-zero, and no time-out occurs. `ident[7:6]` reads 2'b11 with the FIFOs enabled and 2'b00 with them disabled.
- R7: With the FIFOs enabled and `rx_count` non-zero, the fourth `char_tick` pulse with no `rx_push` or `rx_pop` in between makes received data pending. This is a time-out, reported as `ident[3:0]` = 4'b1100. An `rx_push` pulse, an `rx_pop` pulse or an empty FIFO removes it.
- R8: Transmit-empty becomes pending on a 0-to-1 transition of `thr_empty`. It is cleared by `thr_write`, or by `ident_rd` while it is the reported source. An `ident_rd` while a higher source is reported leaves it pending.
- R9: After reset, with quiet inputs, `thr_empty` high and the FIFOs disabled, `ident` reads 8'h01 and `irq` is low. A holding register that is already empty at reset does not arm transmit-empty.
- R10: `ident[5:4]` always reads 2'b00. `ident[3]` is 1 only when the time-out is the reported source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 4 | Source enable bits (see R1) |
| fifo_en | input | 1 | FIFO mode on |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_push | input | 1 | Pulse: character received into the FIFO |
| rx_pop | input | 1 | Pulse: character read by the CPU |
| char_tick | input | 1 | Pulse once per character time |
| line_err | input | 1 | Line status condition pending (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_write | input | 1 | Pulse: holding register written |
| modem_chg | input | 1 | Modem status change pending (level) |
| ident_rd | input | 1 | Pulse: identification value read |
| ident | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume that `rx_count` never exceeds the FIFO depth, so the trigger comparison stays within the count width. The stimulus drives every input just after the rising edge and draws `rx_count` only from 0 to 16. Pulse inputs may be high on any cycle, including several at once. This is why the properties depend only on the stated clear priority of a write over a new empty edge, and never on pulses being one cycle apart.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } irq_src_e;

  localparam int NUM_SRC = 4;

  // priority slot -> identification code (slot 0 is most urgent)
  function automatic irq_src_e slot_code(input logic [1:0] slot);
    case (slot)
      2'd0:    slot_code = SRC_LINE;
      2'd1:    slot_code = SRC_RXDATA;
      2'd2:    slot_code = SRC_THRE;
      default: slot_code = SRC_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int CNT_W = 5,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14
) (
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  output logic             hit
);

  logic [CNT_W-1:0] level;

  always_comb begin
    case (trig_sel)
      2'b00:   level = CNT_W'(LVL_A);
      2'b01:   level = CNT_W'(LVL_B);
      2'b10:   level = CNT_W'(LVL_C);
      default: level = CNT_W'(LVL_D);
    endcase
    hit = (rx_count >= level);
  end

endmodule

// File: rtl/uart_irq_tout.sv
module uart_irq_tout #(
  parameter int CNT_W      = 5,
  parameter int TOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             tout_act
);

  localparam int TW = $clog2(TOUT_CHARS + 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tflag_q, tflag_d;
  logic          restart, adv, upd;

  always_comb begin
    restart = !fifo_en || (rx_count == '0) || rx_push || rx_pop;
    adv     = char_tick && !tflag_q;
    upd     = restart || adv;
    tcnt_d  = tcnt_q;
    tflag_d = tflag_q;
    if (restart) begin
      tcnt_d  = '0;
      tflag_d = 1'b0;
    end else if (adv) begin
      tcnt_d = tcnt_q + TW'(1);
      if (tcnt_q == TW'(TOUT_CHARS - 1)) tflag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      tflag_q <= 1'b0;
    end else if (upd) begin
      tcnt_q  <= tcnt_d;
      tflag_q <= tflag_d;
    end
  end

  assign tout_act = tflag_q && fifo_en && (rx_count != '0);

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic thr_write,
  input  logic rd_clear,
  output logic pend
);

  logic empty_q;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = thr_empty && !empty_q;
    pend_d = pend_q;
    if (thr_write || rd_clear) pend_d = 1'b0;
    else if (rise)             pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [$clog2(N)-1:0] slot
);

  always_comb begin
    any  = 1'b0;
    slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any  = 1'b1;
        slot = ($clog2(N))'(i);
      end
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TOUT_CHARS = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       irq_en,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             line_err,
  input  logic             thr_empty,
  input  logic             thr_write,
  input  logic             modem_chg,
  input  logic             ident_rd,
  output logic [7:0]       ident,
  output logic             irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic trig_hit, tout_act, thre_pend, rx_src;
  logic [NUM_SRC-1:0] req;
  logic any;
  logic [1:0] slot;
  irq_src_e code;
  logic thre_shown;

  uart_irq_trig #(.CNT_W(CNT_W)) u_trig (
    .trig_sel (trig_sel),
    .rx_count (rx_count),
    .hit      (trig_hit)
  );

  uart_irq_tout #(.CNT_W(CNT_W), .TOUT_CHARS(TOUT_CHARS)) u_tout (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .fifo_en   (fifo_en),
    .rx_count  (rx_count),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .char_tick (char_tick),
    .tout_act  (tout_act)
  );

  uart_irq_thre u_thre (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .thr_empty (thr_empty),
    .thr_write (thr_write),
    .rd_clear  (ident_rd && thre_shown),
    .pend      (thre_pend)
  );

  always_comb begin
    rx_src = fifo_en ? (trig_hit || tout_act) : (rx_count != '0);
    req[0] = irq_en[2] && line_err;
    req[1] = irq_en[0] && rx_src;
    req[2] = irq_en[1] && thre_pend;
    req[3] = irq_en[3] && modem_chg;
  end

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .req  (req),
    .any  (any),
    .slot (slot)
  );

  always_comb begin
    code       = any ? slot_code(slot) : SRC_MODEM;
    thre_shown = any && (code == SRC_THRE);
    ident[7:6] = {2{fifo_en}};
    ident[5:4] = 2'b00;
    ident[3]   = any && (code == SRC_RXDATA) && tout_act;
    ident[2:1] = code;
    ident[0]   = !any;
    irq        = any;
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       irq_en,
  input logic             fifo_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic             line_err,
  input logic             thr_write,
  input logic [7:0]       ident,
  input logic             irq
);

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq); // R1

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[2] && line_err) |-> (ident[3:0] == 4'b0110)); // R4

  AST_TRIG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && trig_sel == 2'b11 && rx_count >= CNT_W'(14) && irq_en[0]
     && !(irq_en[2] && line_err)) |-> (ident[2:0] == 3'b100)); // R5

  AST_NO_TOUT_UNBUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !ident[3]); // R6

  AST_TOUT_IS_RXDATA: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3] |-> (ident[2:0] == 3'b100)); // R7

  AST_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> (ident[3:0] != 4'b0010)); // R8

  AST_IRQ_FOLLOWS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != ident[0])); // R2

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_en    (irq_en),
  .fifo_en   (fifo_en),
  .trig_sel  (trig_sel),
  .rx_count  (rx_count),
  .line_err  (line_err),
  .thr_write (thr_write),
  .ident     (ident),
  .irq       (irq)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_en = '0;
  logic       fifo_en = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [4:0] rx_count = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
  logic       line_err = 1'b0, thr_empty = 1'b1, thr_write = 1'b0;
  logic       modem_chg = 1'b0, ident_rd = 1'b0;
  logic [7:0] ident;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .fifo_en(fifo_en),
    .trig_sel(trig_sel), .rx_count(rx_count), .rx_push(rx_push),
    .rx_pop(rx_pop), .char_tick(char_tick), .line_err(line_err),
    .thr_empty(thr_empty), .thr_write(thr_write), .modem_chg(modem_chg),
    .ident_rd(ident_rd), .ident(ident), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_ticks;
  bit m_tout, m_thre, m_prev;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] model_ident();
    logic [7:0] r;
    bit tact, rxd;
    tact = m_tout && fifo_en && (rx_count != 0);
    if (fifo_en) rxd = (int'(rx_count) >= lvl(trig_sel)) || tact;
    else         rxd = (rx_count != 0);
    r = fifo_en ? 8'hC0 : 8'h00;
    if (irq_en[2] && line_err)      r[3:0] = 4'h6;
    else if (irq_en[0] && rxd)      r[3:0] = tact ? 4'hC : 4'h4;
    else if (irq_en[1] && m_thre)   r[3:0] = 4'h2;
    else if (irq_en[3] && modem_chg) r[3:0] = 4'h0;
    else                            r[3:0] = 4'h1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ticks = 0; m_tout = 0; m_thre = 0; m_prev = 1;
    end else begin
      bit shown;
      shown = (model_ident() & 8'h0F) == 8'h02;
      if (!fifo_en || rx_count == 0 || rx_push || rx_pop) begin
        m_ticks = 0; m_tout = 0;
      end else if (char_tick && !m_tout) begin
        m_ticks++;
        if (m_ticks == 4) m_tout = 1;
      end
      if (thr_write || (ident_rd && shown)) m_thre = 0;
      else if (thr_empty && !m_prev)        m_thre = 1;
      m_prev = thr_empty;
    end
  end

  // ---------------- checking ----------------
  task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ident got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s irq got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      logic [7:0] e;
      e = model_ident();
      chk8("R4", ident, e);
      chk1("R2", irq, ~e[0]);
      chk8("R10", {6'b0, ident[5:4]}, 8'h00);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_id(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk8(tag, ident, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    run = 1'b1;
    expect_id("R9", 8'h01);
    chk1("R9", irq, 1'b0);

    // R1: all sources active but masked
    line_err = 1; rx_count = 3; modem_chg = 1; irq_en = 4'h0; step();
    expect_id("R1", 8'h01);
    irq_en = 4'hF; step();
    expect_id("R4", 8'h06);
    chk1("R2", irq, 1'b1);
    irq_en = 4'hB; step();
    expect_id("R1", 8'h04);
    irq_en = 4'hF; line_err = 0; step();
    expect_id("R6", 8'h04);
    rx_count = 0; step();
    expect_id("R3", 8'h00);
    modem_chg = 0; step();
    expect_id("R2", 8'h01);

    // R5: trigger levels
    fifo_en = 1; trig_sel = 2'b10; rx_count = 7; modem_chg = 1; step();
    expect_id("R6", 8'hC0);
    rx_count = 8; step();  expect_id("R5", 8'hC4);
    trig_sel = 2'b11; rx_count = 13; step(); expect_id("R5", 8'hC0);
    rx_count = 14; step(); expect_id("R5", 8'hC4);
    trig_sel = 2'b00; rx_count = 1; step(); expect_id("R5", 8'hC4);
    trig_sel = 2'b01; rx_count = 3; step(); expect_id("R5", 8'hC0);
    rx_count = 4; step(); expect_id("R5", 8'hC4);

    // R7: time-out
    modem_chg = 0; trig_sel = 2'b11; rx_count = 0; step();
    rx_count = 5; rx_push = 1; irq_en = 4'h1; step();
    rx_push = 0;
    for (int i = 0; i < 3; i++) begin
      char_tick = 1; step(); char_tick = 0; step();
    end
    expect_id("R7", 8'hC1);
    char_tick = 1; step(); char_tick = 0;
    expect_id("R7", 8'hCC);
    chk1("R7", irq, 1'b1);
    rx_pop = 1; rx_count = 4; step(); rx_pop = 0;
    expect_id("R7", 8'hC1);

    // R8: transmit-empty
    fifo_en = 0; rx_count = 0; irq_en = 4'h2;
    thr_empty = 0; step(); expect_id("R8", 8'h01);
    thr_empty = 1; step(); expect_id("R8", 8'h02);
    ident_rd = 1; step(); ident_rd = 0; expect_id("R8", 8'h01);
    thr_empty = 0; step(); thr_empty = 1; step(); expect_id("R8", 8'h02);
    thr_write = 1; step(); thr_write = 0; expect_id("R8", 8'h01);
    irq_en = 4'h6; line_err = 1;
    thr_empty = 0; step(); thr_empty = 1; step(); expect_id("R8", 8'h06);
    ident_rd = 1; step(); ident_rd = 0; expect_id("R8", 8'h06);
    line_err = 0; step(); expect_id("R8", 8'h02);

    // mixed stimulus, compared each clock against the model
    for (int c = 0; c < 4000; c++) begin
      irq_en    = 4'($urandom);
      if ($urandom_range(0, 15) == 0) fifo_en  = 1'($urandom);
      if ($urandom_range(0, 7) == 0)  trig_sel = 2'($urandom);
      if ($urandom_range(0, 7) == 0)  rx_count = 5'($urandom_range(0, 16));
      rx_push   = ($urandom_range(0, 15) == 0);
      rx_pop    = ($urandom_range(0, 15) == 0);
      char_tick = 1'($urandom);
      line_err  = ($urandom_range(0, 5) == 0);
      thr_empty = ($urandom_range(0, 3) != 0);
      thr_write = ($urandom_range(0, 7) == 0);
      modem_chg = ($urandom_range(0, 3) == 0);
      ident_rd  = ($urandom_range(0, 3) == 0);
      step();
    end
    @(negedge clk);
    finish_run();
  end

endmodule